// File: doc/BRIEF.md
# PCIe PERST# Reset Sequencer

This block drives the active-low fundamental reset line of one downstream PCIe device. It keeps the line low until the power rails, the reference clock and the card itself have each been reported good for their own minimum time. Only then does it let the device out of reset. Power-good, clock-stable and the active-low card-present input are asynchronous. Each passes through a two-flop synchronizer before any timer sees it. Every delay is a tick count of the free-running system clock, set by a parameter.

The line goes low again as soon as a condition is lost or the card is pulled. It also goes low at once on a software reset request. Any such event restarts every timer from zero. A software request also starts a minimum hold time, which runs from the end of the request. A second output rises a set time after the line is released, to mark when configuration requests may be sent. A separate one-cycle pulse marks each entry of the 5-bit link-training state input into the hot-reset encoding.

Top module: `pcie_perst_seq`

## Requirements
- R1: While `rst_n` is low, `perst_n_o` and `cfg_ready_o` are 0.
- R2: `perst_n_o` rises no sooner than `PWR_TICKS` clock edges after the synchronized power-good input becomes 1. The synchronized value lags the pin by two edges.
- R3: `perst_n_o` rises no sooner than `CLK_TICKS` edges after the synchronized clock-stable input becomes 1. Each condition's timer restarts from zero whenever that condition is 0.
- R4: `perst_n_o` stays 0 while `card_prsnt_n_i` is 1 (no card). It may rise only `CARD_TICKS` edges after the synchronized input goes to 0.
- R5: Loss of power-good or clock-stable, or removal of the card, drops `perst_n_o` once the synchronized value changes. `sw_rst_req_i` = 1 drops it in the same cycle, combinationally. Each of these events clears all condition timers.
- R6: After `sw_rst_req_i` returns to 0, `perst_n_o` stays 0 for at least `SWREQ_TICKS` edges.
- R7: `cfg_ready_o` rises `CFG_TICKS` edges after `perst_n_o` rises. It is 0 whenever `perst_n_o` is 0.
- R8: `hot_reset_pulse_o` is 1 for exactly one cycle when `ltssm_i` changes from another value to `HOT_CODE`. It stays 0 while the state remains there and for all other codes.
- R9: A change on `pwr_good_i`, `refclk_ok_i` or `card_prsnt_n_i` has no effect on `perst_n_o` after one clock edge. It takes effect after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| pwr_good_i | input | 1 | Power rails stable (asynchronous) |
| refclk_ok_i | input | 1 | Reference clock stable (asynchronous) |
| card_prsnt_n_i | input | 1 | Card present, active low (asynchronous) |
| sw_rst_req_i | input | 1 | Software reset request, synchronous |
| ltssm_i | input | LTSSM_W | Link-training state code |
| perst_n_o | output | 1 | Fundamental reset to the device, active low |
| cfg_ready_o | output | 1 | Configuration requests may be issued |
| hot_reset_pulse_o | output | 1 | One-cycle pulse on entry to the hot-reset state |

## Verification
The bench builds the block with PWR_TICKS=40, CLK_TICKS=10, CARD_TICKS=30, SWREQ_TICKS=60, CFG_TICKS=20 and HOT_CODE=5'h0B. These values make every timer a different length. Each release can then be traced to the timer that governs it: the power delay at start-up, the clock delay after a clock-only dropout, and the card delay after re-insertion. With SWREQ_TICKS set longer than the power delay, the software hold time is the last gate, so its own window can be measured. The short counts bring each boundary, one cycle before and at release, within a few hundred cycles.

// File: rtl/perst_seq_pkg.sv
package perst_seq_pkg;
  // width of a counter that must reach the value n (at least one bit)
  function automatic int unsigned cnt_w(input int unsigned n);
    int unsigned w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // release rule: every condition true, every timer expired, no request, hold done
  function automatic logic release_ok(input logic [2:0] ok, input logic [2:0] done,
                                      input logic req, input logic hold_done);
    return (&ok) & (&done) & ~req & hold_done;
  endfunction
endpackage

// File: rtl/perst_sync.sv
module perst_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= async_i[i];
        s2 <= s1;
      end
    end
    assign sync_o[i] = s2;
  end
endmodule

// File: rtl/perst_delay_timer.sv
module perst_delay_timer import perst_seq_pkg::*; #(
  parameter int unsigned TICKS      = 16,
  parameter bit          START_DONE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic done_o
);
  localparam int unsigned CW = cnt_w(TICKS);
  localparam logic [CW-1:0] LIMIT = CW'(TICKS);

  logic [CW-1:0] cnt;

  assign done_o = (cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= START_DONE ? LIMIT : '0;
    else if (clr_i || !run_i) cnt <= '0;
    else if (!done_o)        cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/perst_hot_detect.sv
module perst_hot_detect #(
  parameter int unsigned     LTSSM_W  = 5,
  parameter logic [LTSSM_W-1:0] HOT_CODE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LTSSM_W-1:0] ltssm_i,
  output logic               pulse_o
);
  logic hit, hit_q;

  assign hit = (ltssm_i == HOT_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit;
  end

  assign pulse_o = hit & ~hit_q;
endmodule

// File: rtl/pcie_perst_seq.sv
module pcie_perst_seq import perst_seq_pkg::*; #(
  parameter int unsigned        PWR_TICKS   = 10_000_000,
  parameter int unsigned        CLK_TICKS   = 10_000,
  parameter int unsigned        CARD_TICKS  = 10_000_000,
  parameter int unsigned        SWREQ_TICKS = 1_000,
  parameter int unsigned        CFG_TICKS   = 10_000_000,
  parameter int unsigned        LTSSM_W     = 5,
  parameter logic [LTSSM_W-1:0] HOT_CODE    = 5'h14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_good_i,
  input  logic               refclk_ok_i,
  input  logic               card_prsnt_n_i,
  input  logic               sw_rst_req_i,
  input  logic [LTSSM_W-1:0] ltssm_i,
  output logic               perst_n_o,
  output logic               cfg_ready_o,
  output logic               hot_reset_pulse_o
);
  // condition index: 0 power, 1 reference clock, 2 card present
  localparam int unsigned NCOND = 3;
  localparam int unsigned COND_TICKS [NCOND] = '{PWR_TICKS, CLK_TICKS, CARD_TICKS};

  logic [NCOND-1:0] cond_raw, cond_ok, cond_ok_q, cond_done;
  logic             abort_evt, sw_done, cfg_done;

  assign cond_raw = {~card_prsnt_n_i, refclk_ok_i, pwr_good_i};

  perst_sync #(.W(NCOND)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (cond_raw),
    .sync_o  (cond_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_ok_q <= '0;
    else        cond_ok_q <= cond_ok;
  end

  // a condition falling, or a software request, restarts every timer
  assign abort_evt = (|(cond_ok_q & ~cond_ok)) | sw_rst_req_i;

  for (genvar i = 0; i < NCOND; i++) begin : g_cond
    perst_delay_timer #(.TICKS(COND_TICKS[i]), .START_DONE(1'b0)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (cond_ok[i]),
      .clr_i  (abort_evt),
      .done_o (cond_done[i])
    );
  end

  perst_delay_timer #(.TICKS(SWREQ_TICKS), .START_DONE(1'b1)) u_sw_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (~sw_rst_req_i),
    .clr_i  (sw_rst_req_i),
    .done_o (sw_done)
  );

  assign perst_n_o = release_ok(cond_ok, cond_done, sw_rst_req_i, sw_done);

  perst_delay_timer #(.TICKS(CFG_TICKS), .START_DONE(1'b0)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (perst_n_o),
    .clr_i  (1'b0),
    .done_o (cfg_done)
  );

  assign cfg_ready_o = perst_n_o & cfg_done;

  perst_hot_detect #(.LTSSM_W(LTSSM_W), .HOT_CODE(HOT_CODE)) u_hot (
    .clk     (clk),
    .rst_n   (rst_n),
    .ltssm_i (ltssm_i),
    .pulse_o (hot_reset_pulse_o)
  );
endmodule

// File: rtl/perst_seq_chk.sv
module perst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_req,
  input logic       perst_n,
  input logic       cfg_ready,
  input logic       hot_pulse,
  input logic [2:0] cond_ok,
  input logic [2:0] cond_done,
  input logic       sw_done
);
  AST_PWR_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
    perst_n |-> cond_done[0]); // R2
  AST_CLK_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
    perst_n |-> cond_done[1]); // R3
  AST_CARD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_ok[2] |-> !perst_n); // R4
  AST_SW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> !perst_n); // R5
  AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_done |-> !perst_n); // R6
  AST_CFG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |-> perst_n); // R7
  AST_CFG_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perst_n) |-> !cfg_ready); // R7
  AST_HOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    hot_pulse |=> !hot_pulse); // R8
endmodule

bind pcie_perst_seq perst_seq_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw_req    (sw_rst_req_i),
  .perst_n   (perst_n_o),
  .cfg_ready (cfg_ready_o),
  .hot_pulse (hot_reset_pulse_o),
  .cond_ok   (cond_ok),
  .cond_done (cond_done),
  .sw_done   (sw_done)
);

// File: tb/test_pcie_perst_seq.sv
module test_pcie_perst_seq;
  localparam int unsigned PWR = 40, CLKT = 10, CARD = 30, SWH = 60, CFG = 20;
  localparam logic [4:0] HOT = 5'h0B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr = 1'b0, rclk = 1'b0, card_n = 1'b1, sw = 1'b0;
  logic [4:0] ltssm = 5'h00;
  logic perst_n, cfg_ready, hot_pulse;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  pcie_perst_seq #(
    .PWR_TICKS(PWR), .CLK_TICKS(CLKT), .CARD_TICKS(CARD),
    .SWREQ_TICKS(SWH), .CFG_TICKS(CFG), .LTSSM_W(5), .HOT_CODE(HOT)
  ) i_pcie_perst_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr), .refclk_ok_i(rclk),
    .card_prsnt_n_i(card_n), .sw_rst_req_i(sw), .ltssm_i(ltssm),
    .perst_n_o(perst_n), .cfg_ready_o(cfg_ready), .hot_reset_pulse_o(hot_pulse)
  );

  // {pwr, refclk, card_n, sw, wait edges[7:0], exp perst_n, exp cfg_ready, req[3:0]}
  localparam int NV = 21;
  localparam logic [17:0] VEC [NV] = '{
    {4'b1100, 8'd41, 2'b00, 4'd2},  // R2 power delay not yet over
    {4'b1100, 8'd1,  2'b10, 4'd2},  // R2 released at power delay
    {4'b1000, 8'd1,  2'b10, 4'd9},  // R9 clock loss not yet synchronized
    {4'b1000, 8'd1,  2'b00, 4'd5},  // R5 clock loss drops line
    {4'b1000, 8'd3,  2'b00, 4'd5},  // R5 stays low
    {4'b1100, 8'd37, 2'b00, 4'd5},  // R5 power timer was restarted
    {4'b1100, 8'd1,  2'b10, 4'd5},  // R5 release after full power delay
    {4'b1110, 8'd2,  2'b00, 4'd4},  // R4 card removed
    {4'b1110, 8'd20, 2'b00, 4'd4},  // R4 held while absent
    {4'b1100, 8'd31, 2'b00, 4'd4},  // R4 card delay not yet over
    {4'b1100, 8'd1,  2'b10, 4'd4},  // R4 release at card delay
    {4'b1101, 8'd0,  2'b00, 4'd5},  // R5 request drops line at once
    {4'b1101, 8'd2,  2'b00, 4'd5},  // R5 request held
    {4'b1100, 8'd59, 2'b00, 4'd6},  // R6 hold window not yet over
    {4'b1100, 8'd1,  2'b10, 4'd6},  // R6 release at end of hold
    {4'b1100, 8'd19, 2'b10, 4'd7},  // R7 ready not yet
    {4'b1100, 8'd1,  2'b11, 4'd7},  // R7 ready after delay
    {4'b1000, 8'd2,  2'b00, 4'd7},  // R7 ready falls with line
    {4'b1000, 8'd48, 2'b00, 4'd3},  // R3 long clock outage
    {4'b1100, 8'd11, 2'b00, 4'd3},  // R3 clock delay not yet over
    {4'b1100, 8'd1,  2'b10, 4'd3}   // R3 release at clock delay
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state with all conditions good
    pwr = 1'b1; rclk = 1'b1; card_n = 1'b0;
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk("R1", "perst_n in reset", perst_n, 1'b0);
    chk("R1", "cfg_ready in reset", cfg_ready, 1'b0);
    pwr = 1'b0; rclk = 1'b0; card_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [17:0] e;
      e = VEC[v];
      pwr = e[17]; rclk = e[16]; card_n = e[15]; sw = e[14];
      if (e[13:6] == 8'd0) #1;
      else begin
        repeat (int'(e[13:6])) @(posedge clk);
        @(negedge clk);
      end
      chk($sformatf("R%0d", e[3:0]), $sformatf("vec %0d perst_n", v), perst_n, e[5]);
      chk($sformatf("R%0d", e[3:0]), $sformatf("vec %0d cfg_ready", v), cfg_ready, e[4]);
    end

    // R8: hot-reset entry pulse
    @(negedge clk);
    ltssm = 5'h11;
    #1 chk("R8", "other code no pulse", hot_pulse, 1'b0);
    @(negedge clk);
    ltssm = HOT;
    #1 chk("R8", "pulse on entry", hot_pulse, 1'b1);
    @(negedge clk);
    chk("R8", "no pulse while staying", hot_pulse, 1'b0);
    @(negedge clk);
    chk("R8", "still no pulse", hot_pulse, 1'b0);
    ltssm = 5'h0A;
    @(negedge clk);
    ltssm = HOT;
    #1 chk("R8", "pulse on re-entry", hot_pulse, 1'b1);
    @(negedge clk);
    ltssm = 5'h00;

    // R1: reset asserted mid-operation clears outputs
    rst_n = 1'b0;
    #1 chk("R1", "perst_n on reset", perst_n, 1'b0);
    chk("R1", "cfg_ready on reset", cfg_ready, 1'b0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule